// File: doc/BRIEF.md
# Four-Bank SDRAM Row and Precharge Tracker

This block follows the command stream of a four-bank SDRAM on the controller side. It keeps, for each bank, whether a row is open and which row it is. On every rising clock edge it samples an active-low chip select, a 3-bit command code, a 2-bit bank number and a 12-bit address bus. Activates open rows. Reads and writes start bursts, and the block reports each one with a registered strobe that carries the bank, the open row and the column start address. Precharges close either one bank or all of them.

Address bit 10 has two meanings. On a precharge it chooses between closing all banks and closing only the addressed bank. On a read or write it requests auto-precharge: a per-bank down-counter closes the bank by itself once the burst is finished. The burst length is 2, 4 or 8 beats, with two beats per clock. Illegal sequences raise a one-cycle protocol-error flag and change no state.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A synchronous active-high `rst` closes every bank, cancels every pending auto-precharge and clears `burst_start` and `proto_err` after the next rising edge.
- R2: An activate (cmd 1) to a closed bank opens it after the edge and stores `addr[11:0]` as its row. The bank index is `ba`, with `ba[0]` as the low bit, so 0 through 3 select banks 0 through 3.
- R3: A read (cmd 2) or write (cmd 3) to an open bank with no pending auto-precharge pulses `burst_start` for one cycle after the edge. With it, `burst_bank` carries the bank, `burst_row` the stored row, `burst_col` the value `addr[8:0]`, `burst_write` a 1 for a write, and `burst_autopre` the value of `addr[10]`.
- R4: A precharge (cmd 4) with `addr[10]`=1 closes all banks and cancels their pending auto-precharges. With `addr[10]`=0 it closes only bank `ba`. A precharge to a closed bank is not an error.
- R5: With auto-precharge, the bank closes on the edge N clocks after the command edge, where N is half the burst length. `bl_sel` is sampled with the command: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 give 8 beats.
- R6: A read or write to a bank whose auto-precharge is still pending raises `proto_err` and starts no burst.
- R7: While `cs_n`=1, commands are ignored: no state change, no strobe, no error. Pending auto-precharge countdowns continue.
- R8: An activate to an open bank, or a read or write to a closed bank, pulses `proto_err` for one cycle and leaves the bank state and rows unchanged.
- R9: A refresh (cmd 5) raises `proto_err` if any bank is open. With all banks closed it has no visible effect.
- R10: Command code 0 (no-op) and the unused codes 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| cmd | input | 3 | Command: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| ba | input | 2 | Bank number |
| addr | input | 12 | Row, column and bit-10 option bus |
| bl_sel | input | 2 | Burst length for the current read or write |
| bank_open | output | 4 | One bit per bank, 1 when a row is open |
| bank_row | output | 48 | Open row per bank, bank b at bits [12b+11:12b] |
| burst_start | output | 1 | One-cycle burst start strobe |
| burst_bank | output | 2 | Bank of the started burst |
| burst_row | output | 12 | Row of the started burst |
| burst_col | output | 9 | Column start address |
| burst_write | output | 1 | 1 for a write burst |
| burst_autopre | output | 1 | Burst has auto-precharge |
| proto_err | output | 1 | One-cycle protocol error flag |

## Verification
Two things can happen in the same cycle: an auto-precharge countdown expiring on one bank, and a new command being accepted on another bank. The bench issues a length-8 auto-precharge write to bank 0. It then times a read to bank 3 so that the read is sampled on exactly the edge where bank 0's count runs out. The check after that edge requires bank 0 closed, bank 3 still open, and a burst strobe for bank 3 with bank 3's row. A dropped or delayed update on either path shows up as a wrong open mask or a missing strobe.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } trk_cmd_e;
endpackage

// File: rtl/sdram_cmd_check.sv
module sdram_cmd_check
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 cs_n,
  input  logic [2:0]           cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic                 opt_bit,
  input  logic [NUM_BANKS-1:0] open_vec,
  input  logic [NUM_BANKS-1:0] busy_vec,
  output logic [NUM_BANKS-1:0] act_mask,
  output logic [NUM_BANKS-1:0] close_mask,
  output logic [NUM_BANKS-1:0] ap_mask,
  output logic                 rw_ok,
  output logic                 err
);
  logic [NUM_BANKS-1:0] sel;
  logic is_act, is_rw, is_pre, is_ref, tgt_open, tgt_busy;

  always_comb begin
    sel      = '0;
    sel[ba]  = 1'b1;
    is_act   = !cs_n && (cmd == CMD_ACT);
    is_rw    = !cs_n && (cmd == CMD_RD || cmd == CMD_WR);
    is_pre   = !cs_n && (cmd == CMD_PRE);
    is_ref   = !cs_n && (cmd == CMD_REF);
    tgt_open = open_vec[ba];
    tgt_busy = busy_vec[ba];

    act_mask   = (is_act && !tgt_open) ? sel : '0;
    rw_ok      = is_rw && tgt_open && !tgt_busy;
    ap_mask    = (rw_ok && opt_bit) ? sel : '0;
    close_mask = is_pre ? (opt_bit ? '1 : sel) : '0;
    err        = (is_act && tgt_open) ||
                 (is_rw && !(tgt_open && !tgt_busy)) ||
                 (is_ref && (open_vec != '0));
  end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             close_i,
  input  logic             ap_load_i,
  input  logic [CNT_W-1:0] ap_len_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic             busy_o,
  output logic [ROW_W-1:0] row_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o <= 1'b0;
      left_q <= '0;
      row_o  <= '0;
    end else if (close_i) begin
      open_o <= 1'b0;
      left_q <= '0;
    end else if (act_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end else if (ap_load_i) begin
      left_q <= ap_len_i;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) open_o <= 1'b0;
    end
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int OPT_BIT   = 10,
  parameter int MAX_BL    = 8,
  localparam int BA_W  = $clog2(NUM_BANKS),
  localparam int CNT_W = $clog2(MAX_BL / 2 + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic [2:0]                 cmd,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  input  logic [1:0]                 bl_sel,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic                       burst_start,
  output logic [BA_W-1:0]            burst_bank,
  output logic [ROW_W-1:0]           burst_row,
  output logic [COL_W-1:0]           burst_col,
  output logic                       burst_write,
  output logic                       burst_autopre,
  output logic                       proto_err
);
  logic [NUM_BANKS-1:0] act_mask, close_mask, ap_mask, busy_vec;
  logic                 rw_ok, err;
  logic [CNT_W-1:0]     ap_len;
  logic [ROW_W-1:0]     row_arr [NUM_BANKS];

  always_comb begin
    case (bl_sel)
      2'd0:    ap_len = CNT_W'(1);
      2'd1:    ap_len = CNT_W'(2);
      default: ap_len = CNT_W'(MAX_BL / 2);
    endcase
  end

  sdram_cmd_check #(.NUM_BANKS(NUM_BANKS)) u_check (
    .cs_n       (cs_n),
    .cmd        (cmd),
    .ba         (ba),
    .opt_bit    (addr[OPT_BIT]),
    .open_vec   (bank_open),
    .busy_vec   (busy_vec),
    .act_mask   (act_mask),
    .close_mask (close_mask),
    .ap_mask    (ap_mask),
    .rw_ok      (rw_ok),
    .err        (err)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .act_i     (act_mask[b]),
      .close_i   (close_mask[b]),
      .ap_load_i (ap_mask[b]),
      .ap_len_i  (ap_len),
      .row_i     (addr),
      .open_o    (bank_open[b]),
      .busy_o    (busy_vec[b]),
      .row_o     (row_arr[b])
    );
    assign bank_row[b*ROW_W +: ROW_W] = row_arr[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_start   <= 1'b0;
      burst_bank    <= '0;
      burst_row     <= '0;
      burst_col     <= '0;
      burst_write   <= 1'b0;
      burst_autopre <= 1'b0;
      proto_err     <= 1'b0;
    end else begin
      burst_start <= rw_ok;
      proto_err   <= err;
      if (rw_ok) begin
        burst_bank    <= ba;
        burst_row     <= row_arr[ba];
        burst_col     <= addr[COL_W-1:0];
        burst_write   <= (cmd == CMD_WR);
        burst_autopre <= addr[OPT_BIT];
      end
    end
  end
endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int OPT_BIT   = 10,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cs_n,
  input logic [2:0]                 cmd,
  input logic [BA_W-1:0]            ba,
  input logic [ROW_W-1:0]           addr,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row,
  input logic                       burst_start,
  input logic [BA_W-1:0]            burst_bank,
  input logic                       proto_err
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (bank_open == '0) && !burst_start && !proto_err);

  // R2
  a_r2_activate_opens: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cmd == CMD_ACT && !bank_open[ba]) |=>
      bank_open[$past(ba)] && (bank_row[$past(ba)*ROW_W +: ROW_W] == $past(addr)));

  // R3
  a_r3_burst_on_open_bank: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> bank_open[burst_bank]);

  // R4
  a_r4_precharge_all: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cmd == CMD_PRE && addr[OPT_BIT]) |=> (bank_open == '0));

  // R7
  a_r7_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !burst_start && !proto_err);

  // R8
  a_r8_reactivate_flags: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cmd == CMD_ACT && bank_open[ba]) |=>
      proto_err && (bank_row[$past(ba)*ROW_W +: ROW_W] ==
                    $past(bank_row[ba*ROW_W +: ROW_W])));

  // R9
  a_r9_refresh_busy: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cmd == CMD_REF && bank_open != '0) |=> proto_err);
endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .OPT_BIT   (OPT_BIT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n        (cs_n),
  .cmd         (cmd),
  .ba          (ba),
  .addr        (addr),
  .bank_open   (bank_open),
  .bank_row    (bank_row),
  .burst_start (burst_start),
  .burst_bank  (burst_bank),
  .proto_err   (proto_err)
);

// File: tb/sdram_bank_tracker_test.sv
`timescale 1ns/1ps
module sdram_bank_tracker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'd0;
  logic [11:0] addr = 12'd0;
  logic [1:0]  bl_sel = 2'd0;
  logic [3:0]  bank_open;
  logic [47:0] bank_row;
  logic        burst_start, burst_write, burst_autopre, proto_err;
  logic [1:0]  burst_bank;
  logic [11:0] burst_row;
  logic [8:0]  burst_col;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_bank_tracker uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cmd(cmd), .ba(ba), .addr(addr),
    .bl_sel(bl_sel), .bank_open(bank_open), .bank_row(bank_row),
    .burst_start(burst_start), .burst_bank(burst_bank), .burst_row(burst_row),
    .burst_col(burst_col), .burst_write(burst_write),
    .burst_autopre(burst_autopre), .proto_err(proto_err)
  );

  // {cs_n, cmd, ba, addr, bl_sel, exp_open, exp_err, exp_burst}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 3'd1, 2'd1, 12'h123, 2'd0, 4'b0010, 1'b0, 1'b0}, // R2 act b1
    {1'b0, 3'd1, 2'd2, 12'h456, 2'd0, 4'b0110, 1'b0, 1'b0}, // R2 act b2
    {1'b0, 3'd2, 2'd1, 12'h0AB, 2'd0, 4'b0110, 1'b0, 1'b1}, // R3 read b1
    {1'b0, 3'd1, 2'd1, 12'h000, 2'd0, 4'b0110, 1'b1, 1'b0}, // R8 act open
    {1'b0, 3'd3, 2'd3, 12'h000, 2'd0, 4'b0110, 1'b1, 1'b0}, // R8 wr closed
    {1'b1, 3'd4, 2'd0, 12'h400, 2'd0, 4'b0110, 1'b0, 1'b0}, // R7 deselected
    {1'b0, 3'd5, 2'd0, 12'h000, 2'd0, 4'b0110, 1'b1, 1'b0}, // R9 ref busy
    {1'b0, 3'd4, 2'd2, 12'h000, 2'd0, 4'b0010, 1'b0, 1'b0}, // R4 pre one
    {1'b0, 3'd2, 2'd1, 12'h4FF, 2'd1, 4'b0010, 1'b0, 1'b1}, // R5 rd ap bl4
    {1'b0, 3'd0, 2'd0, 12'h000, 2'd0, 4'b0010, 1'b0, 1'b0}, // R5 count
    {1'b0, 3'd0, 2'd0, 12'h000, 2'd0, 4'b0000, 1'b0, 1'b0}, // R5 closed
    {1'b0, 3'd5, 2'd0, 12'h000, 2'd0, 4'b0000, 1'b0, 1'b0}, // R9 ref idle
    {1'b0, 3'd4, 2'd0, 12'h000, 2'd0, 4'b0000, 1'b0, 1'b0}, // R4 pre closed
    {1'b0, 3'd7, 2'd1, 12'h000, 2'd0, 4'b0000, 1'b0, 1'b0}  // R10 unused
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic [2:0] k, logic [1:0] b,
                      logic [11:0] a, logic [1:0] l);
    @(negedge clk);
    cs_n = c; cmd = k; ba = b; addr = a; bl_sel = l;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset open", 64'(bank_open), 64'h0);
    chk("R1 reset strobes", 64'({burst_start, proto_err}), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      step(v[25], v[24:22], v[21:20], v[19:8], v[7:6]);
      chk($sformatf("R2-vec%0d open", i), 64'(bank_open), 64'(v[5:2]));
      chk($sformatf("R8-vec%0d err", i), 64'(proto_err), 64'(v[1]));
      chk($sformatf("R3-vec%0d burst", i), 64'(burst_start), 64'(v[0]));
    end

    // R2 row capture, R3 burst fields with write and auto-precharge, BL8
    step(1'b0, 3'd1, 2'd0, 12'hABC, 2'd0);
    chk("R2 row bank0", 64'(bank_row[11:0]), 64'hABC);
    step(1'b0, 3'd3, 2'd0, 12'h5A7, 2'd2);
    chk("R3 fields", 64'({burst_start, burst_bank, burst_row, burst_col,
                          burst_write, burst_autopre}),
        64'({1'b1, 2'd0, 12'hABC, 9'h1A7, 1'b1, 1'b1}));
    step(1'b0, 3'd2, 2'd0, 12'h000, 2'd0);
    chk("R6 pending rd", 64'({proto_err, burst_start}), 64'b10);
    step(1'b1, 3'd1, 2'd2, 12'h777, 2'd0);
    chk("R7 ignored act", 64'({bank_open, proto_err, burst_start}), 64'b0001_00);
    step(1'b0, 3'd1, 2'd3, 12'h00F, 2'd0);
    chk("R5 bl8 still open", 64'(bank_open), 64'b1001);
    // coincidence: bank0 expiry on same edge as read to bank3
    step(1'b0, 3'd2, 2'd3, 12'h010, 2'd0);
    chk("R5 bl8 closed", 64'(bank_open), 64'b1000);
    chk("R3 coincident burst", 64'({burst_start, burst_bank, burst_row, burst_col}),
        64'({1'b1, 2'd3, 12'h00F, 9'h010}));

    // R4 precharge all cancels pending auto-precharge
    step(1'b0, 3'd1, 2'd1, 12'h111, 2'd0);
    step(1'b0, 3'd2, 2'd1, 12'h400, 2'd2);
    step(1'b0, 3'd4, 2'd2, 12'h400, 2'd0);
    chk("R4 pre all", 64'(bank_open), 64'h0);
    step(1'b0, 3'd1, 2'd1, 12'h222, 2'd0);
    for (int n = 0; n < 5; n++) step(1'b0, 3'd0, 2'd1, 12'h400, 2'd0);
    chk("R4 pending cancelled", 64'(bank_open), 64'b0010);
    chk("R10 nop row kept", 64'(bank_row[23:12]), 64'h222);

    // R5 BL2 auto-precharge
    step(1'b0, 3'd1, 2'd2, 12'h333, 2'd0);
    step(1'b0, 3'd2, 2'd2, 12'h400, 2'd0);
    chk("R5 bl2 open at start", 64'(bank_open), 64'b0110);
    step(1'b0, 3'd6, 2'd0, 12'h000, 2'd0);
    chk("R5 bl2 closed", 64'(bank_open), 64'b0010);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    step(1'b0, 3'd2, 2'd1, 12'h000, 2'd0);
    chk("R1 mid reset", 64'({bank_open, burst_start, proto_err}), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule